// File: doc/BRIEF.md
# FSK Carrier Qualification and Data Gating

This block sits between an FSK demodulator and the host controller in a caller-number receiver. It takes two per-sample inputs: a flag that says in-band energy is present, and the demodulated bit. It then decides when a carrier is really there, and gates the bit stream onto two outputs.

The active-low carrier indication falls only after the energy flag has stayed high for a qualifying time. It rises again only after the energy has been absent for a hold time, so short dropouts inside a message do not break the carrier. The full data output passes the demodulated bit, including the alternating seizure header, whenever the carrier is qualified. The short data output also waits for an unbroken run of mark bits, so the host sees no seizure preamble on it.

All three timers count ticks of one millisecond. A divider derives these ticks from the system clock. The energy estimator and the demodulator are outside this block.

Top module: `fsk_cd_gate`

## Requirements
- R1: `cd_n` goes low only after `energy_in` has been 1 without a break for ON_MS millisecond ticks (between ON_MS-1 and ON_MS ms). Any cycle with `energy_in` at 0 before that restarts the count.
- R2: While `cd_n` is 1, `data_out` and `short_out` are 0 whatever `bit_in` is.
- R3: While `cd_n` is 0, `data_out` equals `bit_in` in the same cycle, with no added delay. It therefore carries the alternating 1/0 seizure header.
- R4: After `cd_n` falls, `short_out` stays 0 until `bit_in` has been 1 (mark) without a break for MARK_MS ticks. From then until carrier release, `short_out` equals `bit_in` in the same cycle.
- R5: A 0 (space) on `bit_in` during the mark-confirmation window restarts the mark count from zero.
- R6: Once `cd_n` is low, it returns high only after `energy_in` has been 0 without a break for HOLD_MS ticks (between HOLD_MS-1 and HOLD_MS ms). A shorter gap in energy leaves `cd_n` low.
- R7: Carrier release clears the mark qualification. On the next carrier, when marks start together with the energy (the case with no seizure header), `short_out` needs about ON_MS+MARK_MS ms of marks before it passes data.
- R8: After reset, `cd_n` is 1 and `data_out` and `short_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| energy_in | input | 1 | In-band energy present, one flag per sample |
| bit_in | input | 1 | Demodulated bit, 1 = mark, 0 = space |
| cd_n | output | 1 | Carrier detect, active low |
| data_out | output | 1 | Full data output, includes the seizure header |
| short_out | output | 1 | Data output after mark confirmation |

## Verification
Both data outputs are combinational gates on `bit_in` behind registered qualification state. The bench therefore samples them one time unit after it drives `bit_in` in the same cycle. The three timers change state on a millisecond tick whose phase the bench does not model. Each timed edge is checked twice: once just before the earliest cycle it may occur, and once two cycles after the latest.

// File: rtl/fskcd_pkg.sv
package fskcd_pkg;
  // width of a counter that must hold values 0 .. n-1
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fskcd_tick.sv
module fskcd_tick #(
  parameter int CLKS_PER_MS = 3580
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = fskcd_pkg::cnt_w(CLKS_PER_MS);
  localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

  logic [W-1:0] div_q, div_nxt;

  always_comb begin
    if (div_q == LAST) div_nxt = '0;
    else               div_nxt = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end

  assign tick = (div_q == LAST);

  generate
    if (CLKS_PER_MS > 1) begin : g_spacing
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fskcd_carrier.sv
module fskcd_carrier #(
  parameter int ON_MS   = 15,
  parameter int HOLD_MS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic energy_i,
  output logic cd_o
);
  localparam int OW = fskcd_pkg::cnt_w(ON_MS);
  localparam int HW = fskcd_pkg::cnt_w(HOLD_MS);
  localparam logic [OW-1:0] ON_LAST   = OW'(ON_MS - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_MS - 1);

  logic [OW-1:0] on_q, on_nxt;
  logic [HW-1:0] off_q, off_nxt;
  logic          cd_q, cd_nxt;

  always_comb begin
    on_nxt  = on_q;
    off_nxt = off_q;
    cd_nxt  = cd_q;
    if (!cd_q) begin
      off_nxt = '0;
      if (!energy_i) on_nxt = '0;
      else if (tick) begin
        if (on_q == ON_LAST) begin
          cd_nxt = 1'b1;
          on_nxt = '0;
        end else on_nxt = on_q + 1'b1;
      end
    end else begin
      on_nxt = '0;
      if (energy_i) off_nxt = '0;
      else if (tick) begin
        if (off_q == HOLD_LAST) begin
          cd_nxt  = 1'b0;
          off_nxt = '0;
        end else off_nxt = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      off_q <= '0;
      cd_q  <= 1'b0;
    end else begin
      on_q  <= on_nxt;
      off_q <= off_nxt;
      cd_q  <= cd_nxt;
    end
  end

  assign cd_o = cd_q;

  // R1
  cd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_q) |-> $past(energy_i));
  // R6
  cd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_q) |-> !$past(energy_i));
endmodule

// File: rtl/fskcd_mark.sv
module fskcd_mark #(
  parameter int MARK_MS = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cd_i,
  input  logic bit_i,
  output logic ok_o
);
  localparam int MW = fskcd_pkg::cnt_w(MARK_MS);
  localparam logic [MW-1:0] MARK_LAST = MW'(MARK_MS - 1);

  logic [MW-1:0] run_q, run_nxt;
  logic          ok_q, ok_nxt;

  always_comb begin
    run_nxt = run_q;
    ok_nxt  = ok_q;
    if (!cd_i) begin
      run_nxt = '0;
      ok_nxt  = 1'b0;
    end else if (!ok_q) begin
      if (!bit_i) run_nxt = '0;
      else if (tick) begin
        if (run_q == MARK_LAST) begin
          ok_nxt  = 1'b1;
          run_nxt = '0;
        end else run_nxt = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      run_q <= run_nxt;
      ok_q  <= ok_nxt;
    end
  end

  assign ok_o = ok_q;

  // R4
  ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> ($past(bit_i) && $past(cd_i)));
  // R7
  ok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_i && !$past(cd_i)) |-> !ok_q);
endmodule

// File: rtl/fsk_cd_gate.sv
module fsk_cd_gate #(
  parameter int CLKS_PER_MS = 3580,
  parameter int ON_MS       = 15,
  parameter int MARK_MS     = 13,
  parameter int HOLD_MS     = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_in,
  input  logic bit_in,
  output logic cd_n,
  output logic data_out,
  output logic short_out
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       tick, carrier, mark_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  fskcd_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(tick));

  fskcd_carrier #(.ON_MS(ON_MS), .HOLD_MS(HOLD_MS)) u_carrier (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .energy_i(energy_in), .cd_o(carrier));

  fskcd_mark #(.MARK_MS(MARK_MS)) u_mark (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .cd_i(carrier), .bit_i(bit_in), .ok_o(mark_ok));

  assign cd_n      = ~carrier;
  assign data_out  = carrier & bit_in;
  assign short_out = carrier & mark_ok & bit_in;

  // R4
  short_imp_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    short_out |-> data_out);
endmodule

// File: tb/test_fsk_cd_gate.sv
module test_fsk_cd_gate;
  localparam int CLK_PERIOD = 10;
  localparam int MS   = 20;
  localparam int ON   = 15;
  localparam int MARK = 13;
  localparam int HOLD = 30;

  logic clk = 1'b0;
  logic rst_n, energy_in, bit_in;
  logic cd_n, data_out, short_out;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_cd_gate #(.CLKS_PER_MS(MS), .ON_MS(ON), .MARK_MS(MARK), .HOLD_MS(HOLD)) i_fsk_cd_gate (
    .clk(clk), .rst_n(rst_n), .energy_in(energy_in), .bit_in(bit_in),
    .cd_n(cd_n), .data_out(data_out), .short_out(short_out));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // alternating 1/0 header, 8 cycles per bit; optional pass-through check
  task automatic run_alt(input int n, input bit chk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_in = ((i / 8) % 2 == 0);
      #1;
      if (chk) begin
        check("R3 data_out follows header", data_out, bit_in);
        check("R4 short_out silent in header", short_out, 1'b0);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; energy_in = 1'b0; bit_in = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    check("R8 cd_n after reset", cd_n, 1'b1);
    check("R8 data_out after reset", data_out, 1'b0);
    check("R8 short_out after reset", short_out, 1'b0);
  endtask

  task automatic t_burst;
    energy_in = 1'b1; bit_in = 1'b1;
    cyc(10*MS);
    energy_in = 1'b0;
    cyc(2);
    energy_in = 1'b1;
    cyc(10*MS);
    check("R1 broken energy gives no carrier", cd_n, 1'b1);
    check("R2 data_out held low", data_out, 1'b0);
    check("R2 short_out held low", short_out, 1'b0);
    energy_in = 1'b0;
    cyc(4);
  endtask

  task automatic t_seizure;
    energy_in = 1'b1;
    run_alt(14*MS, 0);
    check("R1 cd_n still high before ON_MS", cd_n, 1'b1);
    check("R2 data_out low before carrier", data_out, 1'b0);
    run_alt(MS+2, 0);
    check("R1 cd_n low after ON_MS", cd_n, 1'b0);
    run_alt(20*MS, 1);
    @(negedge clk); bit_in = 1'b1;
    cyc(12*MS);
    check("R4 short_out waits for marks", short_out, 1'b0);
    cyc(MS+2);
    check("R4 short_out valid after marks", short_out, 1'b1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      bit_in = ((i * 37 + 5) % 7) > 2;
      #1;
      check("R4 short_out follows data", short_out, bit_in);
      check("R3 data_out follows data", data_out, bit_in);
    end
  endtask

  task automatic t_hold;
    @(negedge clk); bit_in = 1'b1; energy_in = 1'b0;
    cyc(20*MS);
    check("R6 short gap keeps carrier", cd_n, 1'b0);
    check("R3 data_out during gap", data_out, 1'b1);
    energy_in = 1'b1;
    cyc(2);
    energy_in = 1'b0;
    cyc(29*MS);
    check("R6 cd_n low before HOLD_MS", cd_n, 1'b0);
    cyc(MS+2);
    check("R6 cd_n high after HOLD_MS", cd_n, 1'b1);
    check("R2 data_out low after release", data_out, 1'b0);
    check("R2 short_out low after release", short_out, 1'b0);
  endtask

  task automatic t_offhook;
    bit_in = 1'b1; energy_in = 1'b1;
    cyc(27*MS);
    check("R7 carrier present in marks", cd_n, 1'b0);
    check("R7 short_out needs new mark period", short_out, 1'b0);
    cyc(MS+2);
    check("R7 short_out valid after ON+MARK", short_out, 1'b1);
    energy_in = 1'b0;
    cyc(HOLD*MS+4);
    check("R6 released before next test", cd_n, 1'b1);
  endtask

  task automatic t_space;
    energy_in = 1'b1;
    run_alt(ON*MS+2, 0);
    check("R1 carrier for space test", cd_n, 1'b0);
    @(negedge clk); bit_in = 1'b1;
    cyc(10*MS);
    bit_in = 1'b0;
    cyc(16);
    bit_in = 1'b1;
    cyc(12*MS);
    check("R5 space restarted mark timer", short_out, 1'b0);
    cyc(MS+2);
    check("R5 short_out after restarted marks", short_out, 1'b1);
  endtask

  initial begin
    t_reset();
    t_burst();
    t_seizure();
    t_hold();
    t_offhook();
    t_space();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule